// File: doc/BRIEF.md
# E-paper panel command sequencer

This block runs the full update sequence for a four-colour e-paper panel behind a write-only serial link. A host pulses `start`, and the block takes the panel through its whole power cycle. It first gives the panel a timed hardware reset and confirms that the panel reports idle. It then plays a fixed setup list and, when the host asked for a quick update, a short extra setup list. After that it streams the frame buffer, orders a refresh and a power-down, and finally puts the panel to sleep. Bytes leave through a byte-wide valid/ready handshake towards a serial transmitter. Each byte carries its data/command flag, and a chip-select output frames each group of bytes.

Delays are counted in milliseconds from a prescaler whose input frequency is a parameter. The panel's busy line is active high and passes through a two-flop synchronizer. The host supplies frame bytes combinationally on `fb_data` for the address shown on `fb_addr`. The block raises `done` at the end of a run. If the panel stays busy when it should be idle, the block latches `error`, and only the block reset clears it.

Top module: `epd_seq`

## Requirements
- R1: While `rst_n` is low: `tx_valid`=0, `tx_cs_n`=1, `panel_rst_n`=1, `done`=0 and `error`=0.
- R2: After `start`, `panel_rst_n` stays high for RST_HIGH_MS. It then goes low for exactly RST_LOW_MS×(CLK_HZ/1000) cycles, with no stretching, and returns high for RST_SETTLE_MS. No byte is offered before this settle time ends.
- R3: If synchronized busy is high when the settle time ends, `error` goes high and stays high until `rst_n`. No byte is offered in that state, and `start` has no effect.
- R4: The setup list goes out in this order, with commands at dc=0 and their arguments at dc=1: 0x00 {0x0F,0x29}, 0x50 {0x37}, 0x04 {} (power-on).
- R5: When `partial` is high with `start` and FAST_EN=1, the block waits for idle after the setup list and then sends 0xE0 {0x02} and 0xE6 {0x5D}. When `partial` is low, these bytes are skipped.
- R6: The frame goes out as command 0x10 (dc=0) followed by FB_BYTES data bytes (dc=1). Byte k is the `fb_data` value presented while `fb_addr`=k. `tx_cs_n` goes high for at least one cycle between chunks of CHUNK_BYTES data bytes, and never inside a chunk.
- R7: After the frame, three pairs go out: 0x12/0x00 (refresh), 0x02/0x00 (power-off) and 0x07/0xA5 (sleep). Each pair starts only after synchronized busy has been seen low.
- R8: If busy stays high for IDLE_TIMEOUT_MS in any wait for idle, `error` goes high and no further byte is offered.
- R9: `done` rises after the sleep argument byte is accepted and holds until the next `start`. A `start` while `done` is high runs the whole sequence again.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_dc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| start | input | 1 | Begin an update run |
| partial | input | 1 | Quick update request, sampled with start |
| busy | input | 1 | Panel busy, active high, asynchronous |
| tx_ready | input | 1 | Transmitter accepts byte |
| fb_data | input | 8 | Frame byte at fb_addr |
| tx_valid | output | 1 | Byte offered |
| tx_byte | output | 8 | Byte to send |
| tx_dc | output | 1 | 0 command, 1 data |
| tx_cs_n | output | 1 | Panel chip select, active low |
| panel_rst_n | output | 1 | Panel reset, active low |
| fb_addr | output | $clog2(FB_BYTES) | Frame byte index |
| done | output | 1 | Run finished |
| error | output | 1 | Sticky failure |

## Verification
Two events can fall on the same byte: the end of a chunk and the end of the frame. The bench sizes the frame as a whole number of chunks, so the last data byte closes both. It expects that byte to lead straight into the refresh wait, with no extra chip-select gap and no lost or repeated byte. A second run throttles `tx_ready` so that stalls land on chunk edges and on list entries with no arguments. The scoreboard judges the chip-select gaps and the byte order in both runs.

// File: rtl/epd_seq.sv
module epd_seq #(
  parameter int CLK_HZ          = 100_000_000,
  parameter int RST_HIGH_MS     = 200,
  parameter int RST_LOW_MS      = 2,
  parameter int RST_SETTLE_MS   = 200,
  parameter int IDLE_TIMEOUT_MS = 30000,
  parameter int FB_BYTES        = 5000,
  parameter int CHUNK_BYTES     = 64,
  parameter bit FAST_EN         = 1'b1,
  localparam int FBW            = $clog2(FB_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           partial,
  input  logic           busy,
  input  logic           tx_ready,
  input  logic [7:0]     fb_data,
  output logic           tx_valid,
  output logic [7:0]     tx_byte,
  output logic           tx_dc,
  output logic           tx_cs_n,
  output logic           panel_rst_n,
  output logic [FBW-1:0] fb_addr,
  output logic           done,
  output logic           error
);
  localparam int CPM      = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int LOW_CYC  = RST_LOW_MS * CPM;
  localparam int CKW      = $clog2(CHUNK_BYTES + 1);
  localparam logic [3:0] INIT_END = 4'd9;
  localparam logic [3:0] FAST_END = 4'd15;

  typedef enum logic [4:0] {
    S_IDLE, S_RHI, S_RLO, S_RSET, S_INIT, S_FWAIT, S_FAST, S_FCMD, S_FDAT,
    S_FGAP, S_WREF, S_REF, S_WOFF, S_OFF, S_WSLP, S_SLP, S_DONE, S_ERR
  } st_t;

  function automatic logic [7:0] rom_at(input logic [3:0] i);
    case (i)
      4'd0: return 8'h00;  4'd1: return 8'h02;  4'd2: return 8'h0F;
      4'd3: return 8'h29;  4'd4: return 8'h50;  4'd5: return 8'h01;
      4'd6: return 8'h37;  4'd7: return 8'h04;  4'd8: return 8'h00;
      4'd9: return 8'hE0;  4'd10: return 8'h01; 4'd11: return 8'h02;
      4'd12: return 8'hE6; 4'd13: return 8'h01; 4'd14: return 8'h5D;
      default: return 8'h00;
    endcase
  endfunction

  st_t st, st_n;
  logic [1:0] bsync;
  logic [31:0] pre, msc, tgt;
  logic [1:0] grd;
  logic [3:0] ptr;
  logic [7:0] left;
  logic dph, part_q, bi;
  logic [CKW-1:0] ck;

  wire busy_s   = bsync[1];
  wire fire     = tx_valid & tx_ready;
  wire tmo      = (msc == tgt - 32'd1) && (pre == 32'(CPM - 1));
  wire idle_ok  = !busy_s && grd == 2'd3;
  wire in_rom   = (st == S_INIT) || (st == S_FAST);
  wire rom_idle = !dph && ptr == ((st == S_FAST) ? FAST_END : INIT_END);
  wire fb_last  = fb_addr == FBW'(FB_BYTES - 1);

  always_comb
    case (st)
      S_RHI:   tgt = 32'(RST_HIGH_MS);
      S_RLO:   tgt = 32'(RST_LOW_MS);
      S_RSET:  tgt = 32'(RST_SETTLE_MS);
      default: tgt = 32'(IDLE_TIMEOUT_MS);
    endcase

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE, S_DONE: if (start) st_n = S_RHI;
      S_RHI:  if (tmo) st_n = S_RLO;
      S_RLO:  if (tmo) st_n = S_RSET;
      S_RSET: if (tmo) st_n = busy_s ? S_ERR : S_INIT;
      S_INIT: if (rom_idle) st_n = (part_q && FAST_EN) ? S_FWAIT : S_FCMD;
      S_FWAIT: if (idle_ok) st_n = S_FAST; else if (tmo) st_n = S_ERR;
      S_FAST: if (rom_idle) st_n = S_FCMD;
      S_FCMD: if (fire) st_n = S_FDAT;
      S_FDAT: if (fire && fb_last) st_n = S_WREF;
              else if (fire && ck == CKW'(CHUNK_BYTES - 1)) st_n = S_FGAP;
      S_FGAP: st_n = S_FDAT;
      S_WREF: if (idle_ok) st_n = S_REF; else if (tmo) st_n = S_ERR;
      S_REF:  if (fire && bi) st_n = S_WOFF;
      S_WOFF: if (idle_ok) st_n = S_OFF; else if (tmo) st_n = S_ERR;
      S_OFF:  if (fire && bi) st_n = S_WSLP;
      S_WSLP: if (idle_ok) st_n = S_SLP; else if (tmo) st_n = S_ERR;
      S_SLP:  if (fire && bi) st_n = S_DONE;
      default: st_n = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bsync <= '0; pre <= '0; msc <= '0; grd <= '0;
      ptr <= '0; left <= '0; dph <= 1'b0; part_q <= 1'b0; bi <= 1'b0;
      ck <= '0; fb_addr <= '0;
    end else begin
      st    <= st_n;
      bsync <= {bsync[0], busy};
      if (st_n != st) begin
        pre <= '0; msc <= '0; grd <= '0;
      end else begin
        grd <= (grd == 2'd3) ? grd : grd + 2'd1;
        if (pre == 32'(CPM - 1)) begin pre <= '0; msc <= msc + 32'd1; end
        else pre <= pre + 32'd1;
      end
      if ((st == S_IDLE || st == S_DONE) && start) begin
        part_q <= partial; ptr <= '0; dph <= 1'b0; bi <= 1'b0;
      end
      if (in_rom && fire) begin
        if (!dph) begin
          left <= rom_at(ptr + 4'd1);
          dph  <= rom_at(ptr + 4'd1) != 8'h00;
          ptr  <= ptr + 4'd2;
        end else begin
          ptr  <= ptr + 4'd1;
          left <= left - 8'd1;
          if (left == 8'd1) dph <= 1'b0;
        end
      end
      if (st == S_FCMD && fire) begin fb_addr <= '0; ck <= '0; end
      if (st == S_FDAT && fire) begin
        fb_addr <= fb_addr + 1'b1;
        ck <= (ck == CKW'(CHUNK_BYTES - 1)) ? '0 : ck + 1'b1;
      end
      if ((st == S_REF || st == S_OFF || st == S_SLP) && fire) bi <= ~bi;
    end

  always_comb begin
    tx_valid = 1'b0; tx_byte = 8'h00; tx_dc = 1'b0;
    case (st)
      S_INIT, S_FAST: begin tx_valid = !rom_idle; tx_byte = rom_at(ptr); tx_dc = dph; end
      S_FCMD: begin tx_valid = 1'b1; tx_byte = 8'h10; end
      S_FDAT: begin tx_valid = 1'b1; tx_byte = fb_data; tx_dc = 1'b1; end
      S_REF:  begin tx_valid = 1'b1; tx_byte = bi ? 8'h00 : 8'h12; tx_dc = bi; end
      S_OFF:  begin tx_valid = 1'b1; tx_byte = bi ? 8'h00 : 8'h02; tx_dc = bi; end
      S_SLP:  begin tx_valid = 1'b1; tx_byte = bi ? 8'hA5 : 8'h07; tx_dc = bi; end
      default: ;
    endcase
  end

  assign tx_cs_n     = !(in_rom || st == S_FCMD || st == S_FDAT ||
                         st == S_REF || st == S_OFF || st == S_SLP);
  assign panel_rst_n = st != S_RLO;
  assign done        = st == S_DONE;
  assign error       = st == S_ERR;

  logic [31:0] lo_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lo_run <= '0;
    else lo_run <= panel_rst_n ? '0 : lo_run + 32'd1;

  a_r2_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> lo_run < 32'(LOW_CYC));
  a_r2_low_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_rst_n) |-> lo_run == 32'(LOW_CYC));
  a_r3_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !tx_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_dc));
  a_r7_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_dc && tx_byte == 8'h12 && !$past(tx_valid) |-> !$past(busy, 3));
  a_r6_cs_frames: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cs_n |-> !tx_valid);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
endmodule

// File: tb/epd_seq_tb_top.sv
module epd_seq_tb_top;
  localparam int CHK = 4;
  localparam int FBN = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, partial = 1'b0, tx_ready = 1'b1;
  logic busy;
  logic [7:0] fb_data;
  logic tx_valid, tx_dc, tx_cs_n, panel_rst_n, done, error;
  logic [7:0] tx_byte;
  logic [3:0] fb_addr;

  int total = 0, bad = 0;
  logic [10:0] q[$];
  int busy_cnt = 0, blr = 0, ready_mode = 0, rcnt = 0;
  bit busy_force = 0, stick_ref = 0, saw_gap = 0, held_v = 0, first_seen = 0;
  int lowcnt = 0, since_start = 0, run_bytes = 0;
  logic [8:0] held;

  assign busy    = busy_force || busy_cnt > 0;
  assign fb_data = 8'(int'(fb_addr) * 37 + 5);

  epd_seq #(.CLK_HZ(4000), .RST_HIGH_MS(200), .RST_LOW_MS(2), .RST_SETTLE_MS(200),
            .IDLE_TIMEOUT_MS(50), .FB_BYTES(FBN), .CHUNK_BYTES(CHK), .FAST_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .busy(busy),
    .tx_ready(tx_ready), .fb_data(fb_data), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_dc(tx_dc), .tx_cs_n(tx_cs_n), .panel_rst_n(panel_rst_n), .fb_addr(fb_addr),
    .done(done), .error(error));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit c, input bit g, input bit dc, input logic [7:0] b);
    q.push_back({c, g, dc, b});
  endtask

  task automatic expect_run(input bit part, input bit upto_ref);
    push(0, 0, 0, 8'h00); push(0, 0, 1, 8'h0F); push(0, 0, 1, 8'h29);
    push(0, 0, 0, 8'h50); push(0, 0, 1, 8'h37); push(0, 0, 0, 8'h04);
    if (part) begin
      push(0, 0, 0, 8'hE0); push(0, 0, 1, 8'h02);
      push(0, 0, 0, 8'hE6); push(0, 0, 1, 8'h5D);
    end
    push(0, 0, 0, 8'h10);
    for (int k = 0; k < FBN; k++) push(1, k > 0 && k % CHK == 0, 1, 8'(k * 37 + 5));
    push(0, 0, 0, 8'h12); push(0, 0, 1, 8'h00);
    if (!upto_ref) begin
      push(0, 0, 0, 8'h02); push(0, 0, 1, 8'h00);
      push(0, 0, 0, 8'h07); push(0, 0, 1, 8'hA5);
    end
  endtask

  task automatic go(input bit p);
    @(negedge clk);
    partial = p; start = 1'b1; since_start = 0; first_seen = 0; run_bytes = 0;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; q.delete(); stick_ref = 0; busy_force = 0; busy_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done && !error && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial forever begin
    @(posedge clk); #2;
    rcnt++;
    tx_ready <= (ready_mode == 0) ? 1'b1 : (rcnt % 3 == 0);
  end

  initial forever begin
    @(negedge clk);
    if (busy_cnt > 0) busy_cnt--;
    blr = busy ? 0 : blr + 1;
    since_start++;
    if (tx_cs_n) saw_gap = 1;
    if (held_v) begin
      chk(tx_valid && {tx_dc, tx_byte} == held, "R10 stall hold", {tx_dc, tx_byte}, held);
      held_v = 0;
    end
    if (!panel_rst_n) begin
      lowcnt++;
      if (lowcnt == 1) chk(since_start >= 800 && since_start <= 802, "R2 high phase", since_start, 801);
    end else if (lowcnt > 0) begin
      chk(lowcnt == 8, "R2 low pulse", lowcnt, 8);
      lowcnt = 0;
    end
    if (tx_valid && tx_ready && rst_n) begin
      run_bytes++;
      if (!first_seen) begin
        first_seen = 1;
        chk(since_start >= 1600, "R2 no byte before settle", since_start, 1608);
      end
      if (q.size() == 0) chk(0, "R4 R5 R6 R7 unexpected byte", {tx_dc, tx_byte}, 0);
      else begin
        logic [10:0] e;
        e = q.pop_front();
        chk(tx_dc == e[8] && tx_byte == e[7:0], "R4 R5 R6 R7 stream", {tx_dc, tx_byte}, e[8:0]);
        if (e[10]) chk(saw_gap == e[9], "R6 chunk gap", saw_gap, e[9]);
      end
      saw_gap = 0;
      if (!tx_dc && tx_byte == 8'h12) begin
        if (stick_ref) busy_force = 1; else busy_cnt = 30;
      end
      if (!tx_dc && tx_byte == 8'h02) begin
        chk(blr >= 2, "R7 idle before power-off", blr, 2);
        busy_cnt = 20;
      end
      if (!tx_dc && tx_byte == 8'h07) chk(blr >= 2, "R7 idle before sleep", blr, 2);
    end else if (tx_valid && rst_n) begin
      held = {tx_dc, tx_byte};
      held_v = 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1 tx_valid", tx_valid, 0);
    chk(tx_cs_n, "R1 tx_cs_n", tx_cs_n, 1);
    chk(panel_rst_n, "R1 panel_rst_n", panel_rst_n, 1);
    chk(!done && !error, "R1 done/error", {done, error}, 0);
    rst_n = 1'b1;

    expect_run(0, 0);
    go(0);
    wait_end();
    chk(done && !error, "R9 done after sleep", {done, error}, 2);
    chk(q.size() == 0, "R4 all bytes sent", q.size(), 0);
    repeat (10) @(negedge clk);
    chk(done && !tx_valid, "R9 done held", {done, tx_valid}, 2);

    ready_mode = 1;
    expect_run(1, 0);
    go(1);
    wait_end();
    chk(done && !error, "R5 R9 restart from done", {done, error}, 2);
    chk(q.size() == 0, "R5 fast list complete", q.size(), 0);
    ready_mode = 0;

    do_reset();
    busy_force = 1;
    go(0);
    repeat (1700) @(negedge clk);
    chk(error && !done, "R3 busy after reset", {done, error}, 1);
    chk(run_bytes == 0, "R3 no bytes", run_bytes, 0);
    go(0);
    repeat (20) @(negedge clk);
    chk(error && !tx_valid && run_bytes == 0, "R3 start ignored", {error, tx_valid}, 2);
    busy_force = 0;
    repeat (5) @(negedge clk);
    chk(error, "R3 sticky after busy clears", error, 1);

    do_reset();
    stick_ref = 1;
    expect_run(0, 1);
    go(0);
    wait_end();
    chk(error && !done, "R8 idle timeout", {done, error}, 1);
    chk(q.size() == 0, "R8 bytes up to refresh", q.size(), 0);
    repeat (10) @(negedge clk);
    chk(!tx_valid && run_bytes == FBN + 9, "R8 nothing after timeout", run_bytes, FBN + 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule